// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block is a serial peripheral port for a small processor bus. It exchanges 8-bit frames full duplex, most significant bit first, through a single shift register. The byte the CPU writes is shifted out while the incoming byte is shifted in, so the received byte replaces the transmitted one. A single completion flag reports the end of each frame. Separate transmit-empty or receive-full flags do not exist.

The CPU sees three registers, selected by a 2-bit address. Address 0 is control. Its bits are: bit 0 enable, bit 1 master, bit 2 clock polarity, bit 3 clock phase, bits 5:4 rate select, bit 6 interrupt enable. Address 1 is status, which is read-only. Its bits are: bit 0 frame done, bit 1 write collision, bit 2 mode fault. Address 2 is the data register. A read returns data combinationally in the same cycle. A write takes effect at the clock edge on which select and write are both high. As master, the block drives the serial clock and the outgoing data line. As slave, it follows an external clock and drives its output line only while the low-active select input is asserted. Every pin has its own output-enable, so the pads stay outside the block.

The CPU access is a one-cycle register strobe. There is no stream interface and no back-pressure. Software paces frames through the done flag or the interrupt. A data write made while a frame is in progress is refused and flagged.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset, all output-enables are low, the interrupt request is low, and both the control register and the status register read 0.
- R2: In master mode, a data write while idle starts a frame. The frame sends the written byte MSB first on the master data output. It captures 8 bits MSB first from the master data input, and at the end the data register holds the captured byte.
- R3: As master, the serial clock half-period is 2, 4, 8 or 16 CPU cycles for rate select 0 to 3. The first clock edge comes one half-period after the starting write, and a frame has exactly 16 edges. Between frames the clock rests at the polarity bit, and the clock and data output-enables are high while enable and master are both set.
- R4: With phase 0, each bit is sampled on the first (leading) clock edge of its bit period and the output changes on the second (trailing) edge. With phase 1, the output changes on the leading edge and the bit is sampled on the trailing edge. The leading edge is a rising edge when polarity is 0 and a falling edge when polarity is 1.
- R5: The done bit sets when the 8th trailing edge is processed. The interrupt request equals interrupt enable AND (done OR mode fault). Done clears only when a data-register access follows a status read that showed a flag; a data access alone does not clear it.
- R6: A data write during a frame is ignored: the frame in flight and its result are unchanged, and the collision bit sets. The collision bit clears on a data-register access that follows a status read.
- R7: If the synchronized select input is low while enable and master are set, the mode-fault bit sets, enable and master are cleared, and the clock and data output-enables drop. A control write that follows a status read clears the mode-fault bit.
- R8: In slave mode, while select is high, the slave data output-enable is low and external clock edges do not advance the bit count. With phase 0, the first bit appears on the slave data output once select falls, before any clock edge.
- R9: As slave, the block receives frames correctly when the external clock's high and low phases each last one CPU cycle, which is half the CPU clock rate. The external clock, data input and select pass through synchronizers of equal depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output-enable |
| mosi_i | input | 1 | Master-out line, read as slave |
| mosi_o | output | 1 | Master-out line, driven as master |
| mosi_oe | output | 1 | Master-out output-enable |
| miso_i | input | 1 | Master-in line, read as master |
| miso_o | output | 1 | Master-in line, driven as slave |
| miso_oe | output | 1 | Master-in output-enable |
| ss_n_i | input | 1 | Select, active low |

## Verification
The bench runs all four polarity and phase combinations at all four master rates. It checks the clock against its own edge timeline on every cycle, so a design with a divider off by one, or with a 15th or 17th edge, would show a wrong clock level or a late done. A write made halfway through a frame must leave the exchanged bytes intact; a design that reloads the shifter would send a corrupted frame. The clear sequences are checked on their own: a plain data read must leave done set. Slave tests pulse the clock while select is high, drive frames at half the CPU rate, and check that the first bit appears before any edge in phase 0. A design that counted edges during deselect, or that loaded the first bit late, would return a shifted byte.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int RATE_W = 2;

  typedef struct packed {
    logic              ie;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
  } spi_cfg_t;

  localparam int CFG_W = $bits(spi_cfg_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = 2 ** RATE_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   half;

  assign half = (CNT_W+1)'(2) << rate;
  assign tick = run && ({1'b0, cnt} == half - (CNT_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          clr,
  input  logic          idle,
  input  logic          lead,
  input  logic          trail,
  input  logic          cpha,
  input  logic          sin,
  output logic          sdo,
  output logic [DW-1:0] data,
  output logic          fin
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh;
  logic          ob;
  logic [CW-1:0] cnt;
  logic          sample, shift;

  assign sample = cpha ? trail : lead;
  assign shift  = cpha ? lead : trail;
  assign fin    = trail && (cnt == CW'(DW-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= '0;
      ob  <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      sh  <= ld_data;
      ob  <= ld_data[DW-1];
      cnt <= '0;
    end else begin
      if (sample) sh <= {sh[DW-2:0], sin};
      if (shift || idle) ob <= sh[DW-1];
      if (clr || fin)  cnt <= '0;
      else if (trail)  cnt <= cnt + CW'(1);
    end

  assign sdo  = ob;
  assign data = sh;
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);
  spi_cfg_t      cfg;
  logic          done_f, wcol_f, modf_f, arm, busy, sck_lvl, sl_d;
  logic [2:0]    syn;
  logic          sck_s, mosi_s, ss_s;
  logic          wr_ctrl, wr_data, rd_stat, acc_data;
  logic          m_mode, s_act, fault, load, m_start;
  logic          tick, sl, lead, trail, core_clr, fin, sdo, sin;
  logic [DW-1:0] sh_data;
  logic          unused_wr_hi;

  assign unused_wr_hi = ^bus_wdata[DW-1:CFG_W];

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, mosi_i, sck_i}), .q(syn)
  );
  assign sck_s  = syn[0];
  assign mosi_s = syn[1];
  assign ss_s   = syn[2];

  assign wr_ctrl  = bus_sel &&  bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_data  = bus_sel &&  bus_wr && (bus_addr == ADDR_DATA);
  assign rd_stat  = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
  assign acc_data = bus_sel && (bus_addr == ADDR_DATA);

  assign m_mode  = cfg.en &&  cfg.master;
  assign s_act   = cfg.en && !cfg.master && !ss_s;
  assign fault   = m_mode && !ss_s;
  assign load    = wr_data && !busy;
  assign m_start = load && m_mode;

  spi_baud #(.RATE_W(RATE_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .run(busy && m_mode), .rate(cfg.rate), .tick(tick)
  );

  assign sl       = sck_s ^ cfg.cpol;
  assign lead     = m_mode ? (tick &&  !sck_lvl) : (s_act &&  sl && !sl_d);
  assign trail    = m_mode ? (tick &&   sck_lvl) : (s_act && !sl &&  sl_d);
  assign core_clr = !cfg.en || (!cfg.master && ss_s) || fault;
  assign sin      = m_mode ? miso_i : mosi_s;

  spi_shift_core #(.DW(DW)) i_core (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_data(bus_wdata), .clr(core_clr),
    .idle(!busy), .lead(lead), .trail(trail), .cpha(cfg.cpha), .sin(sin),
    .sdo(sdo), .data(sh_data), .fin(fin)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg     <= '0;
      done_f  <= 1'b0;
      wcol_f  <= 1'b0;
      modf_f  <= 1'b0;
      arm     <= 1'b0;
      busy    <= 1'b0;
      sck_lvl <= 1'b0;
      sl_d    <= 1'b0;
    end else begin
      sl_d <= sl;
      if (wr_ctrl) cfg <= spi_cfg_t'(bus_wdata[CFG_W-1:0]);
      if (fault) begin
        cfg.en     <= 1'b0;
        cfg.master <= 1'b0;
      end
      if (core_clr || fin)                  busy <= 1'b0;
      else if (m_start || (s_act && lead))  busy <= 1'b1;
      if (!busy || !m_mode) sck_lvl <= 1'b0;
      else if (tick)        sck_lvl <= !sck_lvl;
      if (fin)                  done_f <= 1'b1;
      else if (arm && acc_data) done_f <= 1'b0;
      if (wr_data && busy)      wcol_f <= 1'b1;
      else if (arm && acc_data) wcol_f <= 1'b0;
      if (fault)               modf_f <= 1'b1;
      else if (arm && wr_ctrl) modf_f <= 1'b0;
      if (rd_stat)                  arm <= done_f || wcol_f || modf_f;
      else if (acc_data || wr_ctrl) arm <= 1'b0;
    end

  always_comb
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {{(DW-CFG_W){1'b0}}, cfg};
      ADDR_STAT: bus_rdata = {{(DW-3){1'b0}}, modf_f, wcol_f, done_f};
      ADDR_DATA: bus_rdata = sh_data;
      default:   bus_rdata = '0;
    endcase

  assign irq     = cfg.ie && (done_f || modf_f);
  assign sck_o   = cfg.cpol ^ sck_lvl;
  assign sck_oe  = m_mode;
  assign mosi_o  = sdo;
  assign mosi_oe = m_mode;
  assign miso_o  = sdo;
  assign miso_oe = s_act;
endmodule

// File: rtl/spi_duplex_port_chk.sv
module spi_duplex_port_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_o,
  input logic sck_oe,
  input logic miso_oe,
  input logic ss_n_i,
  input logic cfg_cpol,
  input logic busy,
  input logic modf_f,
  input logic done_f,
  input logic wcol_f,
  input logic wr_data
);
  AST_DRV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_oe && miso_oe)); // R8
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !busy) |-> (sck_o == cfg_cpol)); // R3
  AST_MODF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_f) |-> !sck_oe); // R7
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol_f); // R6
  AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(busy)); // R5
  AST_SS_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2)) |-> !miso_oe); // R8
endmodule

bind spi_duplex_port spi_duplex_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .sck_oe(sck_oe), .miso_oe(miso_oe),
  .ss_n_i(ss_n_i), .cfg_cpol(cfg.cpol), .busy(busy), .modf_f(modf_f),
  .done_f(done_f), .wcol_f(wcol_f), .wr_data(wr_data)
);

// File: tb/test_spi_duplex_port.sv
`timescale 1ns/1ps
module test_spi_duplex_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

  int checks = 0, errors = 0, cyc = 0, last_w = 0;
  bit finished = 1'b0;

  // reference state for master frames
  bit mchk = 1'b0;
  int m_w, m_h;
  bit m_cpol;
  // behavioural external slave
  bit mon_on = 1'b0, cpol_b, cpha_b;
  logic [7:0] ext_tx, ext_rx;
  int ext_bit;

  always #2 clk = ~clk;

  spi_duplex_port i_spi_duplex_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    last_w = cyc + 1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // every-cycle comparison of the master pins against the edge timeline
  always @(negedge clk) begin
    if (mchk) begin
      int n, tg;
      n  = cyc - m_w;
      tg = n / m_h;
      if (tg > 16) tg = 16;
      check("R3 sck level", sck_o, m_cpol ^ (tg % 2));
      check("R3 sck_oe", sck_oe, 1);
      check("R3 mosi_oe", mosi_oe, 1);
      check("R8 miso_oe in master", miso_oe, 0);
      check("R5 irq timing", irq, (n >= 16 * m_h) ? 1 : 0);
    end
  end

  always @(sck_o) begin
    if (mon_on) begin
      if ((sck_o ^ cpol_b) == 1'b1) begin
        if (!cpha_b) ext_rx = {ext_rx[6:0], mosi_o};
        else begin
          miso_i = ext_tx[3'(7 - ext_bit)];
          ext_bit = ext_bit + 1;
        end
      end else begin
        if (!cpha_b) begin
          ext_bit = ext_bit + 1;
          if (ext_bit < 8) miso_i = ext_tx[3'(7 - ext_bit)];
        end else ext_rx = {ext_rx[6:0], mosi_o};
      end
    end
  end

  task automatic mxfer(input int rate, input bit cpol, input bit cpha,
                       input logic [7:0] tx, input logic [7:0] etx, input bit coll);
    logic [7:0] d;
    bus_write(2'd0, {1'b0, 1'b1, 2'(rate), cpha, cpol, 1'b1, 1'b1});
    cpol_b = cpol; cpha_b = cpha; ext_tx = etx; ext_rx = 8'h00; ext_bit = 0;
    miso_i = cpha ? 1'b0 : etx[7];
    mon_on = 1'b1;
    m_h = 2 << rate; m_cpol = cpol;
    bus_write(2'd2, tx);
    m_w = last_w;
    mchk = 1'b1;
    if (coll) begin
      repeat (10) @(negedge clk);
      bus_write(2'd2, 8'hFF);
      repeat (16 * m_h - 8) @(negedge clk);
    end else repeat (16 * m_h + 4) @(negedge clk);
    mchk = 1'b0;
    mon_on = 1'b0;
    check("R2 bits seen on master output", ext_rx, tx);
    bus_read(2'd2, d);
    check(coll ? "R6 frame result kept" : "R2 R4 received byte", d, etx);
    bus_read(2'd1, d);
    check(coll ? "R6 collision and done" : "R5 done survives plain data read", d, coll ? 8'h03 : 8'h01);
    bus_read(2'd2, d);
    bus_read(2'd1, d);
    check(coll ? "R6 flags cleared" : "R5 done cleared", d, 8'h00);
    check("R5 irq cleared", irq, 0);
  endtask

  task automatic sxfer(input bit cpol, input bit cpha, input int hp,
                       input logic [7:0] tx, input logic [7:0] mtx,
                       input bit chk_out, input bit pulses);
    logic [7:0] d, got;
    got = 8'h00;
    @(negedge clk); sck_i = cpol;
    bus_write(2'd0, {1'b0, 1'b1, 2'd0, cpha, cpol, 1'b0, 1'b1});
    bus_write(2'd2, tx);
    repeat (3) @(negedge clk);
    check("R8 slave output off while deselected", miso_oe, 0);
    if (pulses) begin
      for (int k = 0; k < 3; k++) begin
        repeat (3) @(negedge clk);
        sck_i = ~sck_i; mosi_i = ~mosi_i;
      end
      repeat (3) @(negedge clk);
      sck_i = cpol;
      repeat (4) @(negedge clk);
    end
    mosi_i = cpha ? 1'b0 : mtx[7];
    @(negedge clk); ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 slave output on when selected", miso_oe, 1);
    if (!cpha) check("R8 first bit before any edge", miso_o, tx[7]);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        repeat (hp) @(negedge clk);
        got[7 - i] = miso_o;
        sck_i = ~cpol;
        repeat (hp) @(negedge clk);
        sck_i = cpol;
        mosi_i = (i < 7) ? mtx[6 - i] : 1'b0;
      end else begin
        repeat (hp) @(negedge clk);
        mosi_i = mtx[7 - i];
        sck_i = ~cpol;
        repeat (hp) @(negedge clk);
        got[7 - i] = miso_o;
        sck_i = cpol;
      end
    end
    repeat (6) @(negedge clk);
    check("R5 irq after slave frame", irq, 1);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    if (chk_out) check("R4 slave sent byte", got, tx);
    bus_read(2'd1, d);
    check("R5 slave done", d, 8'h01);
    bus_read(2'd2, d);
    check(hp == 1 ? "R9 byte at half CPU rate" : "R8 R9 slave received byte", d, mtx);
    bus_read(2'd1, d);
    check("R5 slave done cleared", d, 8'h00);
  endtask

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sck_oe", sck_oe, 0);
    check("R1 mosi_oe", mosi_oe, 0);
    check("R1 miso_oe", miso_oe, 0);
    check("R1 irq", irq, 0);
    bus_read(2'd0, d); check("R1 control", d, 8'h00);
    bus_read(2'd1, d); check("R1 status", d, 8'h00);

    mxfer(0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
    mxfer(1, 1'b1, 1'b0, 8'h81, 8'h7E, 1'b0);
    mxfer(2, 1'b0, 1'b1, 8'h4D, 8'hB2, 1'b0);
    mxfer(3, 1'b1, 1'b1, 8'hF0, 8'h0F, 1'b0);
    mxfer(0, 1'b1, 1'b1, 8'h96, 8'h5A, 1'b1);

    sxfer(1'b0, 1'b0, 6, 8'hC3, 8'h69, 1'b1, 1'b1);
    sxfer(1'b1, 1'b1, 6, 8'h2B, 8'hD4, 1'b1, 1'b0);
    sxfer(1'b0, 1'b0, 1, 8'h11, 8'hE7, 1'b0, 1'b0);
    sxfer(1'b1, 1'b1, 1, 8'h22, 8'h38, 1'b0, 1'b1);

    // mode fault: select driven low while configured as master
    bus_write(2'd0, 8'h43);
    check("R7 drivers on before fault", sck_oe, 1);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 sck_oe dropped", sck_oe, 0);
    check("R7 mosi_oe dropped", mosi_oe, 0);
    check("R7 irq on fault", irq, 1);
    bus_read(2'd1, d); check("R7 fault flag", d, 8'h04);
    bus_read(2'd0, d); check("R7 enable and master cleared", d, 8'h40);
    ss_n_i = 1'b1;
    bus_write(2'd0, 8'h40);
    bus_read(2'd1, d); check("R7 fault flag cleared", d, 8'h00);
    check("R7 irq cleared", irq, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule